// File: doc/BRIEF.md
# Nearest-Template Distance Matcher

This block picks which of a set of enrolled feature vectors lies closest to a freshly projected test vector. The caller first fills an internal training store, one signed element at a time, with `NUM_ROWS` rows of `NUM_FEAT` features each. It then holds a test vector steady on a flat input and pulses `start`. The block walks every element of every stored row through a one-element-per-cycle pipeline. For each pair it takes the signed difference, squares it and adds it to a per-row sum.

The search for the minimum runs alongside the summing, so no vector of distances is ever stored. When a row's last feature has been added, that row's squared distance is compared with the best value found so far. If it is strictly smaller, the running best and its row index are replaced. No square root is taken, because it would not change the ordering. When the last row has been compared, the block raises a one-cycle completion flag. The winning index and its squared distance then stay on the outputs until the next accepted start.

Test and training features must be centred with the same convention before they reach the block.

Top module: `nm_matcher`

## Requirements
- R1: `min_dist` after completion equals the smallest, over all rows r, of the sum over features k of (test[k] - train[r][k])², computed exactly with no square root. Features are signed two's complement values of `FEAT_W` bits. `min_dist` is 2·`FEAT_W`+2+clog2(`NUM_FEAT`) bits wide, 20 bits at the defaults.
- R2: `id` after completion is the row index whose squared distance equals `min_dist`, and it is always less than `NUM_ROWS`.
- R3: When rows tie for the smallest distance, the lowest index is reported, because the compare is strictly less-than.
- R4: `done` is high for exactly one cycle. It rises `NUM_FEAT`·`NUM_ROWS`+1 clock edges after the edge that accepted `start`.
- R5: While no run is active and no start is accepted, `id` and `min_dist` hold their values.
- R6: On the edge that accepts `start`, `min_dist` is loaded with all ones and `id` with 0. These values are visible until the first row is compared.
- R7: A `start` pulse that arrives while a run is active is ignored. The running result, the completion time and the number of completions are all unchanged.
- R8: A cycle with `tr_we` high stores `tr_data` at row `tr_row`, feature `tr_col`. Stored values persist across runs until they are overwritten. Feature k of the test vector sits at `test_vec[k*FEAT_W +: FEAT_W]`.
- R9: After reset, `done` is 0, `id` is 0 and `min_dist` is all ones.
- R10: Extreme inputs (test at the most negative value, training at the most positive value) give exact sums without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a match run when idle |
| test_vec | input | NUM_FEAT*FEAT_W | Test features, feature k at bits k*FEAT_W upward |
| tr_we | input | 1 | Write one training element |
| tr_row | input | clog2(NUM_ROWS) | Training row being written |
| tr_col | input | clog2(NUM_FEAT) | Feature index being written |
| tr_data | input | FEAT_W | Signed training element |
| id | output | clog2(NUM_ROWS) | Index of the closest row |
| min_dist | output | 2*FEAT_W+2+clog2(NUM_FEAT) | Squared distance of the closest row |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that `test_vec` stays constant and that `tr_we` stays low from an accepted start until `done`. A run's result is only defined under that condition. They also assume that writes address only rows and features that exist. The stimulus loads the store and sets the test vector only while the block is idle. It waits for each completion before it changes either of them. The only thing it drives during a run is an extra `start` pulse, which exercises the rule that such a pulse is ignored. The expected index, distance and completion time come from a behavioural model of the stored matrix held in the bench.

// File: rtl/nm_pkg.sv
package nm_pkg;
    localparam int FEAT_W_DEF   = 8;
    localparam int NUM_FEAT_DEF = 4;
    localparam int NUM_ROWS_DEF = 6;

    // index width for a count of n items, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/nm_train_mem.sv
module nm_train_mem #(
    parameter int FEAT_W   = nm_pkg::FEAT_W_DEF,
    parameter int NUM_FEAT = nm_pkg::NUM_FEAT_DEF,
    parameter int NUM_ROWS = nm_pkg::NUM_ROWS_DEF,
    parameter int ROW_W    = nm_pkg::idx_w(NUM_ROWS),
    parameter int COL_W    = nm_pkg::idx_w(NUM_FEAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [FEAT_W-1:0] wdata,
    input  logic [ROW_W-1:0]  rd_row,
    input  logic [COL_W-1:0]  rd_col,
    output logic [FEAT_W-1:0] rd_data
);
    localparam int CELLS = NUM_ROWS * NUM_FEAT;

    logic [CELLS*FEAT_W-1:0] cells_flat;

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_FEAT; c++) begin : g_col
            logic [FEAT_W-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (we && wr_row == ROW_W'(r) && wr_col == COL_W'(c))
                    cell_q <= wdata;
            end
            assign cells_flat[(r*NUM_FEAT+c)*FEAT_W +: FEAT_W] = cell_q;
        end
    end

    int rd_idx;
    always_comb begin
        rd_idx  = int'(rd_row) * NUM_FEAT + int'(rd_col);
        rd_data = cells_flat[rd_idx*FEAT_W +: FEAT_W];
    end
endmodule

// File: rtl/nm_sqdiff.sv
module nm_sqdiff #(
    parameter int FEAT_W = nm_pkg::FEAT_W_DEF,
    parameter int ROW_W  = 3,
    parameter int SQ_W   = 2*FEAT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [FEAT_W-1:0] in_a,
    input  logic [FEAT_W-1:0] in_b,
    output logic              out_valid,
    output logic              out_last,
    output logic [ROW_W-1:0]  out_row,
    output logic [SQ_W-1:0]   out_sq
);
    typedef struct packed {
        logic             valid;
        logic             last;
        logic [ROW_W-1:0] row;
        logic [SQ_W-1:0]  sq;
    } sq_t;

    sq_t sq_d, sq_q;
    logic signed [FEAT_W:0]   diff;
    logic signed [SQ_W-1:0]   prod;

    always_comb begin
        diff       = $signed({in_a[FEAT_W-1], in_a}) - $signed({in_b[FEAT_W-1], in_b});
        prod       = diff * diff;
        sq_d.valid = in_valid;
        sq_d.last  = in_last;
        sq_d.row   = in_row;
        sq_d.sq    = $unsigned(prod);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign out_valid = sq_q.valid;
    assign out_last  = sq_q.last;
    assign out_row   = sq_q.row;
    assign out_sq    = sq_q.sq;
endmodule

// File: rtl/nm_matcher.sv
module nm_matcher #(
    parameter int FEAT_W   = nm_pkg::FEAT_W_DEF,
    parameter int NUM_FEAT = nm_pkg::NUM_FEAT_DEF,
    parameter int NUM_ROWS = nm_pkg::NUM_ROWS_DEF,
    parameter int ROW_W    = nm_pkg::idx_w(NUM_ROWS),
    parameter int COL_W    = nm_pkg::idx_w(NUM_FEAT),
    parameter int SQ_W     = 2*FEAT_W + 2,
    parameter int ACC_W    = SQ_W + nm_pkg::idx_w(NUM_FEAT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_FEAT*FEAT_W-1:0] test_vec,
    input  logic                       tr_we,
    input  logic [ROW_W-1:0]           tr_row,
    input  logic [COL_W-1:0]           tr_col,
    input  logic [FEAT_W-1:0]          tr_data,
    output logic [ROW_W-1:0]           id,
    output logic [ACC_W-1:0]           min_dist,
    output logic                       done
);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(NUM_FEAT - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        logic             busy;
        logic             issue;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] best;
        logic [ROW_W-1:0] best_id;
        logic             done;
    } st_t;

    st_t st_d, st_q;
    logic run_busy;

    logic [FEAT_W-1:0] test_elem;
    logic [FEAT_W-1:0] train_elem;
    logic              sq_valid;
    logic              sq_last;
    logic [ROW_W-1:0]  sq_row;
    logic [SQ_W-1:0]   sq_val;
    logic [ACC_W-1:0]  row_sum;

    assign run_busy = st_q.busy;

    nm_train_mem #(
        .FEAT_W(FEAT_W), .NUM_FEAT(NUM_FEAT), .NUM_ROWS(NUM_ROWS),
        .ROW_W(ROW_W), .COL_W(COL_W)
    ) mem_i (
        .clk(clk), .rst_n(rst_n),
        .we(tr_we), .wr_row(tr_row), .wr_col(tr_col), .wdata(tr_data),
        .rd_row(st_q.row), .rd_col(st_q.col), .rd_data(train_elem)
    );

    always_comb begin
        test_elem = '0;
        for (int k = 0; k < NUM_FEAT; k++) begin
            if (COL_W'(k) == st_q.col) test_elem = test_vec[k*FEAT_W +: FEAT_W];
        end
    end

    nm_sqdiff #(.FEAT_W(FEAT_W), .ROW_W(ROW_W), .SQ_W(SQ_W)) sq_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(st_q.issue), .in_last(st_q.col == COL_LAST), .in_row(st_q.row),
        .in_a(test_elem), .in_b(train_elem),
        .out_valid(sq_valid), .out_last(sq_last), .out_row(sq_row), .out_sq(sq_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        row_sum   = st_q.acc + ACC_W'(sq_val);
        if (!run_busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.issue   = 1'b1;
                st_d.row     = '0;
                st_d.col     = '0;
                st_d.acc     = '0;
                st_d.best    = '1;
                st_d.best_id = '0;
            end
        end else begin
            // element issue walk: features inner, rows outer
            if (st_q.issue) begin
                if (st_q.col == COL_LAST) begin
                    st_d.col = '0;
                    if (st_q.row == ROW_LAST) st_d.issue = 1'b0;
                    else                      st_d.row   = st_q.row + 1'b1;
                end else begin
                    st_d.col = st_q.col + 1'b1;
                end
            end
            // accumulate, and compare once a row is complete
            if (sq_valid) begin
                if (sq_last) begin
                    st_d.acc = '0;
                    if (row_sum < st_q.best) begin
                        st_d.best    = row_sum;
                        st_d.best_id = sq_row;
                    end
                    if (sq_row == ROW_LAST) begin
                        st_d.busy = 1'b0;
                        st_d.done = 1'b1;
                    end
                end else begin
                    st_d.acc = row_sum;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.best <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign id       = st_q.best_id;
    assign min_dist = st_q.best;
    assign done     = st_q.done;
endmodule

// File: rtl/nm_matcher_chk.sv
module nm_matcher_chk #(
    parameter int NUM_ROWS = 6,
    parameter int LAT      = 25,
    parameter int ROW_W    = 3,
    parameter int ACC_W    = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [ROW_W-1:0] id,
    input logic [ACC_W-1:0] min_dist
);
    logic [31:0] lat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               lat_cnt <= '0;
        else if (start && !busy)  lat_cnt <= '0;
        else if (busy)            lat_cnt <= lat_cnt + 1'b1;
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == 32'(LAT)));

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(id) && $stable(min_dist)));

    // R6
    run_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (min_dist == '1 && id == '0));

    // R2
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(id) < NUM_ROWS);

    // R1
    min_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (min_dist <= $past(min_dist)));
endmodule

bind nm_matcher nm_matcher_chk #(
    .NUM_ROWS(NUM_ROWS), .LAT(NUM_FEAT*NUM_ROWS + 1),
    .ROW_W(ROW_W), .ACC_W(ACC_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(run_busy),
    .done(done), .id(id), .min_dist(min_dist)
);

// File: tb/nm_matcher_tb_top.sv
module nm_matcher_tb_top;
    localparam int W     = 8;
    localparam int NF    = 4;
    localparam int NR    = 6;
    localparam int ROW_W = 3;
    localparam int COL_W = 2;
    localparam int ACC_W = 2*W + 2 + 2;
    localparam int LAT   = NF*NR + 1;
    localparam longint ONES = (64'd1 << ACC_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [NF*W-1:0]    test_vec = '0;
    logic               tr_we = 1'b0;
    logic [ROW_W-1:0]   tr_row = '0;
    logic [COL_W-1:0]   tr_col = '0;
    logic [W-1:0]       tr_data = '0;
    logic [ROW_W-1:0]   id;
    logic [ACC_W-1:0]   min_dist;
    logic               done;

    always #2 clk = ~clk;

    nm_matcher dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .test_vec(test_vec),
        .tr_we(tr_we), .tr_row(tr_row), .tr_col(tr_col), .tr_data(tr_data),
        .id(id), .min_dist(min_dist), .done(done)
    );

    typedef struct {
        int     exp_id;
        longint exp_dist;
        int     t0;
        string  tag;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int tm [NR][NF];
    int tv [NF];
    logic prev_done = 1'b0;
    int last_id = 0;
    longint last_dist = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    // monitor: pops expected results as completions appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            check(!prev_done, "R4", "done width", 2, 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected completion", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(int'(id) == it.exp_id, "R2", {it.tag, " id"}, id, it.exp_id);
                check(longint'(min_dist) == it.exp_dist, "R1", {it.tag, " dist"},
                      min_dist, it.exp_dist);
                check(cyc - it.t0 == LAT, "R4", {it.tag, " latency"}, cyc - it.t0, LAT);
                last_id   = int'(id);
                last_dist = longint'(min_dist);
            end
        end
        prev_done = done;
    end

    task automatic wr(input int r, input int c, input int v);
        @(negedge clk);
        tr_we   = 1'b1;
        tr_row  = ROW_W'(r);
        tr_col  = COL_W'(c);
        tr_data = W'(v);
        tm[r][c] = v;
        @(negedge clk);
        tr_we = 1'b0;
    endtask

    task automatic fill_row(input int r, input int v);
        for (int c = 0; c < NF; c++) wr(r, c, v);
    endtask

    task automatic set_test();
        for (int k = 0; k < NF; k++) test_vec[k*W +: W] = W'(tv[k]);
    endtask

    // R8: the driver computes from its own copy of the store
    task automatic run_case(input string tag, input bit extra_start);
        item_t it;
        longint best = ONES;
        int     bid  = 0;
        set_test();
        for (int r = 0; r < NR; r++) begin
            longint s = 0;
            for (int k = 0; k < NF; k++) s += longint'((tv[k]-tm[r][k])*(tv[k]-tm[r][k]));
            if (s < best) begin best = s; bid = r; end
        end
        @(negedge clk);
        it.exp_id = bid; it.exp_dist = best; it.t0 = cyc + 1; it.tag = tag;
        exp_q.push_back(it);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R6 cleared result right after the accepting edge
        check(longint'(min_dist) == ONES, "R6", {tag, " init dist"}, min_dist, ONES);
        check(id == '0, "R6", {tag, " init id"}, id, 0);
        if (extra_start) begin
            repeat (6) @(negedge clk);
            start = 1'b1;   // R7 must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        // R5 hold after completion
        check(int'(id) == last_id, "R5", {tag, " id hold"}, id, last_id);
        check(longint'(min_dist) == last_dist, "R5", {tag, " dist hold"}, min_dist, last_dist);
        check(!done, "R7", {tag, " no second done"}, done, 0);
    endtask

    initial begin
        for (int r = 0; r < NR; r++) for (int k = 0; k < NF; k++) tm[r][k] = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!done, "R9", "reset done", done, 0);
        check(id == '0, "R9", "reset id", id, 0);
        check(longint'(min_dist) == ONES, "R9", "reset dist", min_dist, ONES);
        rst_n = 1'b1;
        @(negedge clk);

        // exact match on row 3
        for (int r = 0; r < NR; r++)
            for (int k = 0; k < NF; k++) wr(r, k, r*20 - 50 + k*3);
        for (int k = 0; k < NF; k++) tv[k] = tm[3][k];
        run_case("R1 exact", 1'b0);

        // R8 same store, different test vector
        tv = '{-45, -40, 3, 0};
        run_case("R8 reuse", 1'b0);

        // R8 overwrite a row so it becomes the match
        for (int k = 0; k < NF; k++) wr(2, k, tv[k]);
        run_case("R8 overwrite", 1'b0);

        // R3 tie between rows 1 and 4
        for (int r = 0; r < NR; r++) fill_row(r, 100);
        fill_row(1, 10);
        fill_row(4, 10);
        tv = '{11, 9, 12, 10};
        run_case("R3 tie", 1'b0);

        // R3 all rows equal -> row 0
        for (int r = 0; r < NR; r++) fill_row(r, 127);
        tv = '{-128, -128, -128, -128};
        run_case("R3 all equal", 1'b0);

        // R10 extreme values, row 5 slightly closer
        fill_row(5, 126);
        run_case("R10 extreme", 1'b0);

        // R7 extra start during a run
        tv = '{0, 1, 2, 3};
        run_case("R7 busy start", 1'b1);

        // R2 varied patterns
        for (int n = 0; n < 6; n++) begin
            for (int r = 0; r < NR; r++)
                for (int k = 0; k < NF; k++) wr(r, k, int'($urandom_range(255)) - 128);
            for (int k = 0; k < NF; k++) tv[k] = int'($urandom_range(255)) - 128;
            run_case("R2 varied", 1'b0);
        end

        finish_run();
    end
endmodule